// File: doc/BRIEF.md
# Five-Valued Gate Evaluator for Fault Calculus

This block evaluates one logic gate over the five symbols used when a good machine and a faulty machine are simulated side by side: 0, 1, D (good 1, faulty 0), D' (good 0, faulty 1) and X. Each input symbol is split into a good component and a faulty component, each one of 0, 1 or unknown. The gate is evaluated once per component in three-valued logic, and the two results are joined back into one symbol. If either component stays unknown, the result is X.

The block also classifies the gate for a test-generation search. It takes the value already assigned to the gate output and reports three flags. The gate is on the D-frontier when a fault effect waits at its inputs behind an undetermined output. It is on the J-frontier when an assigned output is not yet implied by its inputs. The conflict flag is set when the inputs imply a value that differs from the assigned one. The block is purely combinational. The decision and backtracking search that uses it is outside the block.

Top module: `fv_gate_eval`

## Requirements
- R1: Symbol codes on every 3-bit port are 0 = logic 0, 1 = logic 1, 2 = D (good 1, faulty 0), 3 = D' (good 0, faulty 1), 4 = X. The output code is always one of these five values. It is D or D' exactly when the good and faulty results are both known and differ, and it is X when either result is unknown.
- R2: AND (gate_sel 0) and NAND (gate_sel 2) are evaluated per component. In a component, any 0 among the used inputs forces 0 even when other inputs are unknown. Otherwise any unknown gives unknown, and otherwise the result is 1. NAND inverts that result.
- R3: OR (gate_sel 1) and NOR (gate_sel 3) are evaluated per component. In a component, any 1 forces 1. Otherwise any unknown gives unknown, and otherwise the result is 0. NOR inverts that result.
- R4: The inverting gates (NAND, NOR, NOT) swap D and D' and leave X as X. NOT (gate_sel 4) of D gives D'.
- R5: XOR (gate_sel 6) gives, per component, the parity of the used inputs, or unknown if any used input is unknown in that component.
- R6: NOT (gate_sel 4) and BUF (gate_sel 5) read only input slot 0 (bits 2:0 of in_codes), whatever the value of in_used. Slots 1 to 3 have no effect on them.
- R7: A slot whose in_used bit is 0 behaves as the non-controlling value of the gate: 1 for AND/NAND and 0 for OR/NOR/XOR. With no slot used, AND gives 1, OR gives 0 and XOR gives 0.
- R8: d_frontier is 1 exactly when the assigned output is X, the evaluated output is X, and at least one effective input slot carries D or D'.
- R9: j_frontier is 1 exactly when the assigned output is known (codes 0 to 3) and the evaluated output is X. It is never set together with d_frontier.
- R10: out_conflict is 1 exactly when both the assigned and the evaluated outputs are known and they differ.
- R11: Input and assigned codes 5 to 7 are read as X. gate_sel 7 is undefined and gives X.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gate_sel | input | 3 | Gate type: 0 AND, 1 OR, 2 NAND, 3 NOR, 4 NOT, 5 BUF, 6 XOR |
| in_codes | input | 12 | Four input symbols, slot i at bits 3i+2:3i |
| in_used | input | 4 | One bit per slot; 0 ties the slot to the non-controlling value |
| out_assigned | input | 3 | Symbol already assigned to the gate output by the search |
| out_code | output | 3 | Evaluated output symbol |
| d_frontier | output | 1 | Gate lies on the D-frontier |
| j_frontier | output | 1 | Gate lies on the J-frontier |
| out_conflict | output | 1 | Implied output contradicts the assigned output |

## Verification
The bench drives each gate type with every combination of the five symbols on four inputs. It compares the result with a model that orders 0 < X < 1 and takes minimum and maximum per component. This exposes a design that lets X swamp a controlling 0 or 1, which would give X for AND(0, X). It also exposes a design that evaluates whole symbols, and so gives X instead of 0 for AND(D, D'). Sweeps of the usage mask catch unused slots tied to the wrong constant, and NOT or BUF reading a slot other than 0. Sweeps of the assigned value catch frontier flags that ignore the evaluated output, and a conflict reported as a J-frontier entry.

// File: rtl/fv_pkg.sv
package fv_pkg;
    localparam int CODE_W = 3;
    localparam int COMP_W = 2;

    // Five-valued symbol codes
    localparam logic [2:0] SYM_ZERO = 3'd0;
    localparam logic [2:0] SYM_ONE  = 3'd1;
    localparam logic [2:0] SYM_DG   = 3'd2;
    localparam logic [2:0] SYM_DB   = 3'd3;
    localparam logic [2:0] SYM_X    = 3'd4;

    // Gate selectors
    localparam logic [2:0] GT_AND  = 3'd0;
    localparam logic [2:0] GT_OR   = 3'd1;
    localparam logic [2:0] GT_NAND = 3'd2;
    localparam logic [2:0] GT_NOR  = 3'd3;
    localparam logic [2:0] GT_NOT  = 3'd4;
    localparam logic [2:0] GT_BUF  = 3'd5;
    localparam logic [2:0] GT_XOR  = 3'd6;

    // Three-valued component: bit 1 set means unknown
    localparam logic [1:0] C0 = 2'b00;
    localparam logic [1:0] C1 = 2'b01;
    localparam logic [1:0] CX = 2'b10;

    function automatic logic [1:0] fv_good(input logic [2:0] s);
        case (s)
            SYM_ZERO: return C0;
            SYM_ONE:  return C1;
            SYM_DG:   return C1;
            SYM_DB:   return C0;
            default:  return CX;
        endcase
    endfunction

    function automatic logic [1:0] fv_faulty(input logic [2:0] s);
        case (s)
            SYM_ZERO: return C0;
            SYM_ONE:  return C1;
            SYM_DG:   return C0;
            SYM_DB:   return C1;
            default:  return CX;
        endcase
    endfunction

    function automatic logic [2:0] fv_join(input logic [1:0] g, input logic [1:0] f);
        if (g[1] || f[1]) return SYM_X;
        case ({g[0], f[0]})
            2'b00:   return SYM_ZERO;
            2'b11:   return SYM_ONE;
            2'b10:   return SYM_DG;
            default: return SYM_DB;
        endcase
    endfunction

    function automatic logic fv_known(input logic [2:0] s);
        return s <= SYM_DB;
    endfunction
endpackage

// File: rtl/fv_comp_eval.sv
module fv_comp_eval
    import fv_pkg::*;
#(
    parameter int N_IN = 4
) (
    input  logic [2:0]             gate_sel,
    input  logic [N_IN-1:0]        used,
    input  logic [N_IN*COMP_W-1:0] comps,
    output logic [1:0]             res
);
    localparam int CW = COMP_W;

    logic       has0, has1, hasx, par;
    logic [1:0] neutral, v_and, v_or, v_xor;

    function automatic logic [1:0] inv3(input logic [1:0] c);
        return c[1] ? CX : {1'b0, ~c[0]};
    endfunction

    always_comb begin
        neutral = (gate_sel == GT_AND || gate_sel == GT_NAND) ? C1 : C0;
        has0 = 1'b0;
        has1 = 1'b0;
        hasx = 1'b0;
        par  = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            logic [1:0] c;
            c = used[i] ? comps[CW*i +: CW] : neutral;
            if (c[1])      hasx = 1'b1;
            else if (c[0]) begin has1 = 1'b1; par = ~par; end
            else           has0 = 1'b1;
        end
        v_and = has0 ? C0 : (hasx ? CX : C1);
        v_or  = has1 ? C1 : (hasx ? CX : C0);
        v_xor = hasx ? CX : {1'b0, par};
        case (gate_sel)
            GT_AND:  res = v_and;
            GT_NAND: res = inv3(v_and);
            GT_OR:   res = v_or;
            GT_NOR:  res = inv3(v_or);
            GT_BUF:  res = v_or;
            GT_NOT:  res = inv3(v_or);
            GT_XOR:  res = v_xor;
            default: res = CX;
        endcase
    end

    // Controlling values dominate unknowns within a component
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            if (gate_sel == GT_AND && used[i] && comps[CW*i +: CW] == C0) begin
                p_and_ctrl_r2: assert (res == C0)
                    else $error("AND with a 0 input did not give 0");
            end
            if (gate_sel == GT_OR && used[i] && comps[CW*i +: CW] == C1) begin
                p_or_ctrl_r3: assert (res == C1)
                    else $error("OR with a 1 input did not give 1");
            end
        end
    end
endmodule

// File: rtl/fv_frontier.sv
module fv_frontier
    import fv_pkg::*;
#(
    parameter int N_IN = 4
) (
    input  logic [N_IN*CODE_W-1:0] ins,
    input  logic [N_IN-1:0]        used,
    input  logic [2:0]             assigned,
    input  logic [2:0]             evaluated,
    output logic                   on_d,
    output logic                   on_j,
    output logic                   conflict
);
    logic has_fe, asg_known, ev_known;

    always_comb begin
        has_fe = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (used[i] && (ins[CODE_W*i +: CODE_W] == SYM_DG ||
                            ins[CODE_W*i +: CODE_W] == SYM_DB))
                has_fe = 1'b1;
        end
        asg_known = fv_known(assigned);
        ev_known  = fv_known(evaluated);
        on_d      = !asg_known && !ev_known && has_fe;
        on_j      = asg_known && !ev_known;
        conflict  = asg_known && ev_known && (assigned != evaluated);
    end

    always_comb begin
        p_excl_frontiers_r9: assert (!(on_d && on_j))
            else $error("gate on both frontiers");
        p_conflict_not_j_r10: assert (!(conflict && on_j))
            else $error("conflict flagged as J-frontier");
    end
endmodule

// File: rtl/fv_gate_eval.sv
module fv_gate_eval
    import fv_pkg::*;
#(
    parameter int N_IN = 4
) (
    input  logic [2:0]             gate_sel,
    input  logic [N_IN*CODE_W-1:0] in_codes,
    input  logic [N_IN-1:0]        in_used,
    input  logic [2:0]             out_assigned,
    output logic [2:0]             out_code,
    output logic                   d_frontier,
    output logic                   j_frontier,
    output logic                   out_conflict
);
    localparam int PW = N_IN * COMP_W;

    logic [N_IN-1:0]  eff_used;
    logic [1:0][PW-1:0] pair_c;
    logic [1:0][1:0]    res_c;

    // Single-input gates look at slot 0 only
    assign eff_used = (gate_sel == GT_NOT || gate_sel == GT_BUF)
                      ? N_IN'(1) : in_used;

    for (genvar i = 0; i < N_IN; i++) begin : g_split
        assign pair_c[0][COMP_W*i +: COMP_W] = fv_good(in_codes[CODE_W*i +: CODE_W]);
        assign pair_c[1][COMP_W*i +: COMP_W] = fv_faulty(in_codes[CODE_W*i +: CODE_W]);
    end

    for (genvar k = 0; k < 2; k++) begin : g_machine
        fv_comp_eval #(.N_IN(N_IN)) u_comp (
            .gate_sel (gate_sel),
            .used     (eff_used),
            .comps    (pair_c[k]),
            .res      (res_c[k])
        );
    end

    assign out_code = fv_join(res_c[0], res_c[1]);

    fv_frontier #(.N_IN(N_IN)) u_front (
        .ins       (in_codes),
        .used      (eff_used),
        .assigned  (out_assigned),
        .evaluated (out_code),
        .on_d      (d_frontier),
        .on_j      (j_frontier),
        .conflict  (out_conflict)
    );

    always_comb begin
        p_code_range_r1: assert (out_code <= SYM_X)
            else $error("output code out of range");
        if (gate_sel == GT_NOT && in_codes[2:0] == SYM_DG) begin
            p_not_swaps_r4: assert (out_code == SYM_DB)
                else $error("NOT of D did not give D'");
        end
    end
endmodule

// File: tb/fv_gate_eval_tb.sv
module fv_gate_eval_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  gate_sel = 3'd0;
    logic [11:0] in_codes = 12'd0;
    logic [3:0]  in_used = 4'hF;
    logic [2:0]  out_assigned = 3'd4;
    logic [2:0]  out_code;
    logic        d_frontier, j_frontier, out_conflict;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fv_gate_eval u_dut (
        .gate_sel     (gate_sel),
        .in_codes     (in_codes),
        .in_used      (in_used),
        .out_assigned (out_assigned),
        .out_code     (out_code),
        .d_frontier   (d_frontier),
        .j_frontier   (j_frontier),
        .out_conflict (out_conflict)
    );

    // Level scale: 0 = low, 1 = unknown, 2 = high
    function automatic int lvl(int code, bit faulty);
        case (code)
            0: return 0;
            1: return 2;
            2: return faulty ? 0 : 2;
            3: return faulty ? 2 : 0;
            default: return 1;
        endcase
    endfunction

    function automatic int eval_lvl(int gate, int codes, int mask, bit faulty);
        int lo = 2, hi = 0, ones = 0, unk = 0, m;
        m = (gate == 4 || gate == 5) ? 1 : mask;
        for (int i = 0; i < 4; i++) begin
            int v;
            if ((m >> i) & 1) v = lvl((codes >> (3*i)) & 7, faulty);
            else              v = (gate == 0 || gate == 2) ? 2 : 0;
            if (v < lo) lo = v;
            if (v > hi) hi = v;
            if (v == 1) unk = 1;
            if (v == 2) ones++;
        end
        case (gate)
            0: return lo;
            2: return 2 - lo;
            1, 5: return hi;
            3, 4: return 2 - hi;
            6: return unk ? 1 : ((ones % 2) * 2);
            default: return 1;
        endcase
    endfunction

    function automatic int to_code(int g, int f);
        if (g == 1 || f == 1) return 4;
        if (g == 2) return (f == 2) ? 1 : 2;
        return (f == 2) ? 3 : 0;
    endfunction

    function automatic string gate_tag(int gate);
        case (gate)
            0, 2: return "R2/R4";
            1, 3: return "R3/R4";
            4, 5: return "R6/R4";
            6: return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic run_vec(string tag, int gate, int codes, int mask, int asg);
        int ev, ed, ej, ec, fe, m, a;
        @(posedge clk);
        #1;
        gate_sel     = 3'(gate);
        in_codes     = 12'(codes);
        in_used      = 4'(mask);
        out_assigned = 3'(asg);
        @(negedge clk);
        ev = to_code(eval_lvl(gate, codes, mask, 1'b0), eval_lvl(gate, codes, mask, 1'b1));
        m  = (gate == 4 || gate == 5) ? 1 : mask;
        fe = 0;
        for (int i = 0; i < 4; i++) begin
            int c;
            c = (codes >> (3*i)) & 7;
            if (((m >> i) & 1) && (c == 2 || c == 3)) fe = 1;
        end
        a  = (asg > 4) ? 4 : asg;
        ed = (a == 4 && ev == 4 && fe == 1) ? 1 : 0;
        ej = (a != 4 && ev == 4) ? 1 : 0;
        ec = (a != 4 && ev != 4 && a != ev) ? 1 : 0;
        checks++;
        if (int'(out_code) != ev || int'(d_frontier) != ed ||
            int'(j_frontier) != ej || int'(out_conflict) != ec) begin
            fails++;
            $display("FAIL %s %s gate=%0d in=%h used=%b asg=%0d: got %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     tag, gate_tag(gate), gate, codes, mask, asg,
                     out_code, d_frontier, j_frontier, out_conflict, ev, ed, ej, ec);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: state after reset with all-zero AND inputs
        run_vec("R1 reset", 0, 0, 15, 4);
        // R1 R2 R3 R4 R5: every gate, every symbol combination, all slots used
        for (int g = 0; g < 7; g++)
            for (int c = 0; c < 625; c++) begin
                int codes = 0, t = c;
                for (int i = 0; i < 4; i++) begin
                    codes |= (t % 5) << (3*i);
                    t /= 5;
                end
                run_vec("R1 full", g, codes, 15, 4);
            end
        // R6 R7: usage mask sweep
        for (int g = 0; g < 7; g++)
            for (int mk = 0; mk < 16; mk++)
                for (int c = 0; c < 625; c += 3) begin
                    int codes = 0, t = c;
                    for (int i = 0; i < 4; i++) begin
                        codes |= (t % 5) << (3*i);
                        t /= 5;
                    end
                    run_vec("R7 mask", g, codes, mk, 4);
                end
        // R8 R9 R10: assigned output sweep
        for (int g = 0; g < 7; g++)
            for (int a = 0; a < 5; a++)
                for (int c = 0; c < 625; c++) begin
                    int codes = 0, t = c;
                    for (int i = 0; i < 4; i++) begin
                        codes |= (t % 5) << (3*i);
                        t /= 5;
                    end
                    run_vec("R8/R9/R10 assigned", g, codes, 15, a);
                end
        // R11: out-of-range codes and undefined gate
        run_vec("R11 code5", 0, 12'o5111, 15, 4);
        run_vec("R11 code7", 1, 12'o7000, 15, 1);
        run_vec("R11 asg6", 0, 12'o2111, 15, 6);
        run_vec("R11 gate7", 7, 12'o1111, 15, 0);
        // R4: NOT of D gives D'
        run_vec("R4 notD", 4, 12'o0002, 0, 4);
        // R6: BUF ignores slots 1..3
        run_vec("R6 buf", 5, 12'o3320, 15, 4);
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 190000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule